// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer with Priority-Level Update

This block times the acknowledge sequence that a small 16-bit processor core runs once it has decided to take an interrupt. It receives a one-cycle accept strobe together with the class of the interrupt source, the priority level of the request (used only for maskable requests), whether the vector address is odd, whether the stack pointer is odd, and whether the core currently runs on a narrow 8-bit bus. From these it derives the exact number of clock cycles the sequence occupies and counts them down.

When the count runs out, the block raises a one-clock done pulse. In that same cycle it loads its processor priority-level register with a value that depends on the source class. A maskable request installs its own level. Fault-type sources force the highest level. Software and debug-related sources leave the level as it was. Arbitration, register stacking, vector fetches and the latency of the instruction being completed are handled elsewhere.

Top module: `irq_ack_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `busy_o`, `done_o` and `ipl_o` (level 0) after that edge.
- R2: On the 16-bit bus (`bus8_i`=0), for source classes with no extra cycles, `done_o` is high exactly N cycles after the cycle in which the accept was sampled. N is 18 with both parities even, 19 with exactly one of `vec_odd_i`/`sp_odd_i` set, and 20 with both set.
- R3: On the 8-bit bus (`bus8_i`=1), the base length is 20 cycles whatever the two parity inputs are.
- R4: Class code 3 (debug) adds 2 cycles to the base length of R2/R3.
- R5: Class codes 2 (address match) and 4 (single step) add 1 cycle to the base length.
- R6: Class code 0 (maskable) loads `ipl_o` with the `req_level_i` value captured at accept, in the done cycle.
- R7: Class code 7 (fault-type: oscillation fault, watchdog, non-maskable pin) loads `ipl_o` with 7 in the done cycle.
- R8: Class codes 1 (software), 2, 3 and 4, and the unused codes 5 and 6, leave `ipl_o` unchanged. Codes 5 and 6 also use the base length.
- R9: `ipl_o` changes only in a cycle where `done_o` is high.
- R10: `busy_o` is high from the cycle after the accept until the cycle before `done_o`, and low in the done cycle. An accept strobe while `busy_o` is high changes neither the timing nor the level result, and produces no extra done pulse.
- R11: `done_o` is high for exactly one clock per accepted sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| accept_i | input | 1 | Interrupt taken strobe, sampled when idle |
| src_class_i | input | 3 | Source class code (see R4 to R8) |
| req_level_i | input | 3 | Priority level of a maskable request |
| vec_odd_i | input | 1 | Vector address is odd |
| sp_odd_i | input | 1 | Stack pointer is odd |
| bus8_i | input | 1 | 1 selects the 8-bit bus, 0 the 16-bit bus |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| ipl_o | output | 3 | Current processor priority level |

## Verification
The bench builds the block with its default parameters: a 3-bit level, a 5-bit counter and the down-counting timer variant. With these settings every sequence length from 18 to 22 cycles is reachable, and so is the fault level 7 at the top of the level range. It sweeps all eight class codes against all eight combinations of parity and bus width, and measures the accept-to-done distance and the resulting level for each one. It also drives an accept strobe into a running sequence and applies a reset in the middle of a sequence.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

   typedef enum logic [2:0] {
      SRC_MASKABLE    = 3'd0,
      SRC_SOFTWARE    = 3'd1,
      SRC_ADDR_MATCH  = 3'd2,
      SRC_DEBUG       = 3'd3,
      SRC_SINGLE_STEP = 3'd4,
      SRC_RSVD5       = 3'd5,
      SRC_RSVD6       = 3'd6,
      SRC_FAULT       = 3'd7
   } src_class_e;

   localparam int unsigned DEF_WIDE_BASE   = 18;
   localparam int unsigned DEF_NARROW_LEN  = 20;
   localparam int unsigned DEF_DEBUG_EXTRA = 2;
   localparam int unsigned DEF_STEP_EXTRA  = 1;
   localparam int unsigned DEF_FAULT_LEVEL = 7;

endpackage

// File: rtl/irq_seq_len.sv
module irq_seq_len
   import irq_ack_pkg::*;
#(
   parameter int unsigned CNT_W       = 5,
   parameter int unsigned WIDE_BASE   = DEF_WIDE_BASE,
   parameter int unsigned NARROW_LEN  = DEF_NARROW_LEN,
   parameter int unsigned DEBUG_EXTRA = DEF_DEBUG_EXTRA,
   parameter int unsigned STEP_EXTRA  = DEF_STEP_EXTRA
) (
   input  src_class_e       cls,
   input  logic             vec_odd,
   input  logic             sp_odd,
   input  logic             bus8,
   output logic [CNT_W-1:0] len
);

   logic [CNT_W-1:0] base_len;
   logic [CNT_W-1:0] extra_len;

   always_comb begin
      if (bus8) begin
         base_len = CNT_W'(NARROW_LEN);
      end else begin
         base_len = CNT_W'(WIDE_BASE) + CNT_W'(vec_odd) + CNT_W'(sp_odd);
      end
   end

   always_comb begin
      unique case (cls)
         SRC_DEBUG:       extra_len = CNT_W'(DEBUG_EXTRA);
         SRC_ADDR_MATCH,
         SRC_SINGLE_STEP: extra_len = CNT_W'(STEP_EXTRA);
         default:         extra_len = '0;
      endcase
   end

   assign len = base_len + extra_len;

endmodule

// File: rtl/irq_ipl_sel.sv
module irq_ipl_sel
   import irq_ack_pkg::*;
#(
   parameter int unsigned LEVEL_W     = 3,
   parameter int unsigned FAULT_LEVEL = DEF_FAULT_LEVEL
) (
   input  src_class_e         cls,
   input  logic [LEVEL_W-1:0] req_level,
   input  logic [LEVEL_W-1:0] cur_level,
   output logic [LEVEL_W-1:0] next_level
);

   always_comb begin
      unique case (cls)
         SRC_MASKABLE: next_level = req_level;
         SRC_FAULT:    next_level = LEVEL_W'(FAULT_LEVEL);
         default:      next_level = cur_level;
      endcase
   end

endmodule

// File: rtl/irq_seq_timer.sv
module irq_seq_timer #(
   parameter int unsigned CNT_W      = 5,
   parameter bit          COUNT_DOWN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [CNT_W-1:0] len,
   output logic             busy,
   output logic             expire
);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (COUNT_DOWN) begin : g_down
         // Load the full length, finish on the edge that sees 1.
         assign expire = busy && (cnt_q == CNT_W'(1));

         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q <= '0;
               busy  <= 1'b0;
            end else if (start) begin
               cnt_q <= len;
               busy  <= 1'b1;
            end else if (expire) begin
               cnt_q <= '0;
               busy  <= 1'b0;
            end else if (busy) begin
               cnt_q <= cnt_q - CNT_W'(1);
            end
         end
      end else begin : g_up
         // Count up from 1 and compare with the captured length.
         logic [CNT_W-1:0] lim_q;

         assign expire = busy && (cnt_q == lim_q);

         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q <= '0;
               lim_q <= '0;
               busy  <= 1'b0;
            end else if (start) begin
               cnt_q <= CNT_W'(1);
               lim_q <= len;
               busy  <= 1'b1;
            end else if (expire) begin
               cnt_q <= '0;
               busy  <= 1'b0;
            end else if (busy) begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
   import irq_ack_pkg::*;
#(
   parameter int unsigned LEVEL_W     = 3,
   parameter int unsigned CNT_W       = 5,
   parameter int unsigned WIDE_BASE   = DEF_WIDE_BASE,
   parameter int unsigned NARROW_LEN  = DEF_NARROW_LEN,
   parameter int unsigned DEBUG_EXTRA = DEF_DEBUG_EXTRA,
   parameter int unsigned STEP_EXTRA  = DEF_STEP_EXTRA,
   parameter int unsigned FAULT_LEVEL = DEF_FAULT_LEVEL,
   parameter bit          COUNT_DOWN  = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               accept_i,
   input  logic [2:0]         src_class_i,
   input  logic [LEVEL_W-1:0] req_level_i,
   input  logic               vec_odd_i,
   input  logic               sp_odd_i,
   input  logic               bus8_i,
   output logic               busy_o,
   output logic               done_o,
   output logic [LEVEL_W-1:0] ipl_o
);

   localparam int unsigned WIDE_MAX  = WIDE_BASE + 2;
   localparam int unsigned BASE_MAX  = (WIDE_MAX > NARROW_LEN) ? WIDE_MAX : NARROW_LEN;
   localparam int unsigned EXTRA_MAX = (DEBUG_EXTRA > STEP_EXTRA) ? DEBUG_EXTRA : STEP_EXTRA;
   localparam int unsigned LEN_MAX   = BASE_MAX + EXTRA_MAX;

   if (FAULT_LEVEL >= (1 << LEVEL_W)) begin : g_bad_fault_level
      $error("FAULT_LEVEL does not fit in LEVEL_W bits");
   end
   if (LEN_MAX >= (1 << CNT_W)) begin : g_bad_cnt_width
      $error("CNT_W too narrow for the longest sequence");
   end
   if (WIDE_BASE < 2 || NARROW_LEN < 2) begin : g_bad_base
      $error("sequence length must be at least 2 cycles");
   end

   logic             start;
   logic [CNT_W-1:0] seq_len;
   logic             expire;
   src_class_e       cls_q;
   logic [LEVEL_W-1:0] lvl_q;
   logic [LEVEL_W-1:0] ipl_q;
   logic [LEVEL_W-1:0] ipl_next;
   logic             done_q;

   assign start = accept_i && !busy_o;

   irq_seq_len #(
      .CNT_W      (CNT_W),
      .WIDE_BASE  (WIDE_BASE),
      .NARROW_LEN (NARROW_LEN),
      .DEBUG_EXTRA(DEBUG_EXTRA),
      .STEP_EXTRA (STEP_EXTRA)
   ) u_len (
      .cls    (src_class_e'(src_class_i)),
      .vec_odd(vec_odd_i),
      .sp_odd (sp_odd_i),
      .bus8   (bus8_i),
      .len    (seq_len)
   );

   irq_seq_timer #(
      .CNT_W     (CNT_W),
      .COUNT_DOWN(COUNT_DOWN)
   ) u_timer (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .len   (seq_len),
      .busy  (busy_o),
      .expire(expire)
   );

   // Capture the class and level of the taken request for the end of the sequence.
   always_ff @(posedge clk) begin
      if (rst) begin
         cls_q <= SRC_SOFTWARE;
         lvl_q <= '0;
      end else if (start) begin
         cls_q <= src_class_e'(src_class_i);
         lvl_q <= req_level_i;
      end
   end

   irq_ipl_sel #(
      .LEVEL_W    (LEVEL_W),
      .FAULT_LEVEL(FAULT_LEVEL)
   ) u_ipl (
      .cls       (cls_q),
      .req_level (lvl_q),
      .cur_level (ipl_q),
      .next_level(ipl_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ipl_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= expire;
         if (expire) begin
            ipl_q <= ipl_next;
         end
      end
   end

   assign done_o = done_q;
   assign ipl_o  = ipl_q;

endmodule

// File: rtl/irq_ack_seq_chk.sv
module irq_ack_seq_chk #(
   parameter int unsigned LEVEL_W     = 3,
   parameter int unsigned FAULT_LEVEL = 7
) (
   input logic               clk,
   input logic               rst,
   input logic               accept_i,
   input logic [2:0]         src_class_i,
   input logic [LEVEL_W-1:0] req_level_i,
   input logic               busy_o,
   input logic               done_o,
   input logic [LEVEL_W-1:0] ipl_o
);

   logic [2:0]         seen_cls;
   logic [LEVEL_W-1:0] seen_lvl;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_cls <= 3'd1;
         seen_lvl <= '0;
      end else if (accept_i && !busy_o) begin
         seen_cls <= src_class_i;
         seen_lvl <= req_level_i;
      end
   end

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (!busy_o && !done_o && ipl_o == '0));

   a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   a_r9_ipl_only_at_done: assert property (@(posedge clk) disable iff (rst)
      (ipl_o != $past(ipl_o)) |-> done_o);

   a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
      (accept_i && !busy_o) |=> busy_o);

   a_r10_done_follows_busy: assert property (@(posedge clk) disable iff (rst)
      done_o |-> ($past(busy_o) && !busy_o));

   a_r6_maskable_level: assert property (@(posedge clk) disable iff (rst)
      (done_o && seen_cls == 3'd0) |-> (ipl_o == seen_lvl));

   a_r7_fault_level: assert property (@(posedge clk) disable iff (rst)
      (done_o && seen_cls == 3'd7) |-> (ipl_o == LEVEL_W'(FAULT_LEVEL)));

   a_r8_level_kept: assert property (@(posedge clk) disable iff (rst)
      (done_o && seen_cls != 3'd0 && seen_cls != 3'd7) |-> (ipl_o == $past(ipl_o)));

endmodule

bind irq_ack_seq irq_ack_seq_chk #(
   .LEVEL_W    (LEVEL_W),
   .FAULT_LEVEL(FAULT_LEVEL)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .accept_i   (accept_i),
   .src_class_i(src_class_i),
   .req_level_i(req_level_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .ipl_o      (ipl_o)
);

// File: tb/tb_irq_ack_seq.sv
module tb_irq_ack_seq;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       accept_i = 1'b0;
   logic [2:0] src_class_i = 3'd0;
   logic [2:0] req_level_i = 3'd0;
   logic       vec_odd_i = 1'b0;
   logic       sp_odd_i = 1'b0;
   logic       bus8_i = 1'b0;
   logic       busy_o;
   logic       done_o;
   logic [2:0] ipl_o;

   irq_ack_seq dut (
      .clk        (clk),
      .rst        (rst),
      .accept_i   (accept_i),
      .src_class_i(src_class_i),
      .req_level_i(req_level_i),
      .vec_odd_i  (vec_odd_i),
      .sp_odd_i   (sp_odd_i),
      .bus8_i     (bus8_i),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .ipl_o      (ipl_o)
   );

   always #5 clk = ~clk;

   typedef struct {
      int    acc_cyc;
      int    len;
      int    cls;
      int    lvl;
      string len_tag;
   } item_t;

   item_t q[$];
   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   int    model_ipl = 0;
   bit    prev_done = 1'b0;
   bit    finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_len(int cls, bit vo, bit so, bit b8);
      int n;
      n = b8 ? 20 : (18 + int'(vo) + int'(so));
      if (cls == 3) n += 2;
      else if (cls == 2 || cls == 4) n += 1;
      return n;
   endfunction

   function automatic string len_tag(int cls, bit b8);
      if (cls == 3) return "R4 debug length";
      if (cls == 2 || cls == 4) return "R5 match/step length";
      if (b8) return "R3 narrow bus length";
      return "R2 wide bus length";
   endfunction

   // Monitor: compare each done pulse against the scoreboard front.
   always @(negedge clk) begin
      item_t it;
      int    exp_ipl;
      if (!rst && !finished) begin
         if (prev_done) chk(done_o == 1'b0, "R11 done width", int'(done_o), 0);
         if (done_o) begin
            if (q.size() == 0) begin
               chk(1'b0, "R10 done without accepted request", 1, 0);
            end else begin
               it = q.pop_front();
               if (it.cls == 0) exp_ipl = it.lvl;
               else if (it.cls == 7) exp_ipl = 7;
               else exp_ipl = model_ipl;
               chk((cyc - it.acc_cyc) == it.len, it.len_tag, cyc - it.acc_cyc, it.len);
               chk(int'(ipl_o) == exp_ipl,
                   (it.cls == 0) ? "R6 maskable level" :
                   (it.cls == 7) ? "R7 fault level" : "R8 level kept",
                   int'(ipl_o), exp_ipl);
               model_ipl = exp_ipl;
            end
         end else begin
            chk(int'(ipl_o) == model_ipl, "R9 level held between pulses", int'(ipl_o), model_ipl);
         end
         prev_done = done_o;
      end
   end

   task automatic push_seq(int cls, int lvl, bit vo, bit so, bit b8);
      item_t it;
      @(negedge clk);
      src_class_i = 3'(cls);
      req_level_i = 3'(lvl);
      vec_odd_i   = vo;
      sp_odd_i    = so;
      bus8_i      = b8;
      accept_i    = 1'b1;
      it.acc_cyc  = cyc + 1;
      it.len      = exp_len(cls, vo, so, b8);
      it.cls      = cls;
      it.lvl      = lvl;
      it.len_tag  = len_tag(cls, b8);
      q.push_back(it);
      @(negedge clk);
      accept_i = 1'b0;
      chk(busy_o == 1'b1, "R10 busy after accept", int'(busy_o), 1);
   endtask

   task automatic wait_idle();
      while (q.size() != 0) @(negedge clk);
      chk(busy_o == 1'b0, "R10 idle at done", int'(busy_o), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
      chk(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
      chk(ipl_o == 3'd0, "R1 reset level", int'(ipl_o), 0);
      rst = 1'b0;

      // Sweep every class code against all parity and bus-width combinations.
      for (int cls = 0; cls < 8; cls++) begin
         for (int k = 0; k < 8; k++) begin
            push_seq(cls, (cls * 5 + k * 3 + 1) % 8, k[0], k[1], k[2]);
            wait_idle();
         end
      end

      // R10: an accept while busy must neither retime nor relevel the sequence.
      push_seq(0, 2, 1'b0, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      src_class_i = 3'd7;
      req_level_i = 3'd6;
      bus8_i      = 1'b1;
      accept_i    = 1'b1;
      @(negedge clk);
      accept_i = 1'b0;
      chk(busy_o == 1'b1, "R10 busy kept after ignored accept", int'(busy_o), 1);
      wait_idle();
      repeat (30) @(negedge clk);
      chk(busy_o == 1'b0, "R10 no second sequence", int'(busy_o), 0);

      // R1: reset in the middle of a sequence drops it and clears the level.
      push_seq(7, 0, 1'b1, 1'b1, 1'b0);
      repeat (5) @(negedge clk);
      rst = 1'b1;
      q.delete();
      repeat (2) @(negedge clk);
      chk(busy_o == 1'b0, "R1 mid-run reset busy", int'(busy_o), 0);
      chk(ipl_o == 3'd0, "R1 mid-run reset level", int'(ipl_o), 0);
      model_ipl = 0;
      prev_done = 1'b0;
      rst = 1'b0;
      repeat (30) @(negedge clk);
      chk(done_o == 1'b0, "R1 no done after reset", int'(done_o), 0);

      // Back to normal operation after the reset.
      push_seq(0, 5, 1'b1, 1'b0, 1'b0);
      wait_idle();

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule